// File: doc/BRIEF.md
# DMA Trigger Source Router

This block sits beside an interrupt controller and decides which peripheral event starts each of four high-speed DMA channels. Every channel has its own 4-bit source code. The codes are written as bytes over a small configuration port, with two codes in each byte. Each code picks one entry from that channel's 16-entry source map. The map covers a software strike, the falling and rising edges of a per-channel port pin, two port input groups, timer underflow and compare events, serial buffer events, ADC completion and I2C read and write requests.

When the selected event occurs and the DMA side has that channel enabled, the block raises a single-cycle request on the next clock. The block never looks at interrupt flags, enables, priorities or IDMA requests, and it never writes them. A peripheral's interrupt therefore still reaches the interrupt controller after the transfer, exactly as it would without DMA.

Top module: `dma_trig_router`

## Requirements
- R1: After reset every channel's source code is 0000 (software strike) and `dma_req` is all zeros.
- R2: A byte written to configuration register index 0 sets channel 0's code from bits [3:0] and channel 1's code from bits [7:4]. Index 1 sets channels 2 and 3 in the same layout.
- R3: With code 0000, a one on `sw_trig[c]` gives a request on channel c. With any other code, `sw_trig[c]` has no effect.
- R4: Code 0001 requests once when `edge_pin[c]` goes from 1 to 0. A pin that stays low or stays high gives no further request.
- R5: Code 0010 requests once when `edge_pin[c]` goes from 0 to 1. A pin that stays high or stays low gives no further request.
- R6: Codes 0011 to 1110 select, in order: port group A, port group B, 8-bit timer underflow, 16-bit timer compare B, 16-bit timer compare A, shared 16-bit timer compare B, shared 16-bit timer compare A, serial receive full, serial transmit empty, ADC done, I2C read request and I2C write request. Per-channel inputs use bit c.
- R7: The shared sources (codes 1000 to 1011) use bit 0 for channels 0 and 2 and bit 1 for channels 1 and 3. ADC done (1100) is common to all channels.
- R8: A channel whose `dma_en` bit is 0 never requests, whatever its source does.
- R9: Code 1111 is reserved and never produces a request.
- R10: A request appears in the clock cycle after the cycle in which the selected event is sampled. It lasts one cycle for each event cycle, so two back-to-back event cycles give two request cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 1 | Configuration register index |
| cfg_wdata | input | 8 | Configuration byte: two source codes |
| sw_trig | input | 4 | Write-one software strike per channel |
| dma_en | input | 4 | Channel enable from the DMA side |
| edge_pin | input | 4 | Edge-detected port pin per channel |
| port_grp_a | input | 4 | Port input group A event per channel |
| port_grp_b | input | 4 | Port input group B event per channel |
| tmr8_uf | input | 4 | 8-bit timer underflow per channel |
| tmr16_cmpb | input | 4 | 16-bit timer compare B per channel |
| tmr16_cmpa | input | 4 | 16-bit timer compare A per channel |
| tmr16x_cmpb | input | 2 | Shared 16-bit timer compare B, one per channel pair |
| tmr16x_cmpa | input | 2 | Shared 16-bit timer compare A, one per channel pair |
| sio_rx_full | input | 2 | Serial receive buffer full, one per channel pair |
| sio_tx_empty | input | 2 | Serial transmit buffer empty, one per channel pair |
| adc_done | input | 1 | ADC conversion done, common to all channels |
| i2c_rd_req | input | 4 | I2C read DMA request per channel |
| i2c_wr_req | input | 4 | I2C write DMA request per channel |
| dma_req | output | 4 | Registered single-cycle DMA request per channel |

## Verification
The software strike is applied in single-channel, alternating and all-channel patterns. This separates per-channel routing from a common fault, and it shows that the enable gating and the code-0000 restriction act per channel. Port pins are driven high and held, then low and held, and they are also toggled in mixed patterns. This tells an edge from a level and rising from falling. Every source family is pulsed one bit at a time under every code, so a swapped map entry or a wrong pair index shows up as a request on the wrong channel. Back-to-back event cycles and the reserved code complete the set.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [3:0] {
    SRC_SW       = 4'd0,
    SRC_PIN_FALL = 4'd1,
    SRC_PIN_RISE = 4'd2,
    SRC_GRP_A    = 4'd3,
    SRC_GRP_B    = 4'd4,
    SRC_T8_UF    = 4'd5,
    SRC_T16_CB   = 4'd6,
    SRC_T16_CA   = 4'd7,
    SRC_T16X_CB  = 4'd8,
    SRC_T16X_CA  = 4'd9,
    SRC_SIO_RX   = 4'd10,
    SRC_SIO_TX   = 4'd11,
    SRC_ADC      = 4'd12,
    SRC_I2C_RD   = 4'd13,
    SRC_I2C_WR   = 4'd14,
    SRC_RSVD     = 4'd15
  } src_code_e;

  localparam int SEL_W     = $bits(src_code_e);
  localparam int SRC_COUNT = 1 << SEL_W;
  localparam int BYTE_W    = 8;

  // channel -> index of the shared peripheral it listens to
  function automatic int pair_of(input int ch, input int num_pair);
    return ch % num_pair;
  endfunction

  // configuration register that holds a channel's code
  function automatic int reg_of(input int ch);
    return ch / (BYTE_W / SEL_W);
  endfunction

  // bit offset of a channel's code inside its register
  function automatic int lane_of(input int ch);
    return (ch % (BYTE_W / SEL_W)) * SEL_W;
  endfunction

  // one entry of a channel's source map
  function automatic logic pick_src(input logic [SRC_COUNT-1:0] srcs,
                                    input logic [SEL_W-1:0] code);
    return srcs[code];
  endfunction

endpackage

// File: rtl/dtr_cfg_regs.sv
module dtr_cfg_regs import dtr_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int AW     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [NUM_CH*SEL_W-1:0] sel_flat
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    localparam int REG  = reg_of(c);
    localparam int LANE = lane_of(c);
    logic [SEL_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= SRC_SW;
      end else if (we && (addr == AW'(REG))) begin
        code_q <= wdata[LANE +: SEL_W];
      end
    end

    assign sel_flat[c*SEL_W +: SEL_W] = code_q;
  end

endmodule

// File: rtl/dtr_edge_det.sv
module dtr_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] pin_q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin;
  end

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;

endmodule

// File: rtl/dtr_chan_sel.sv
module dtr_chan_sel import dtr_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] srcs,
  input  logic [SEL_W-1:0]     code,
  input  logic                 en,
  output logic                 req
);

  logic hit;
  assign hit = en & pick_src(srcs, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= hit;
  end

endmodule

// File: rtl/dma_trig_router.sv
module dma_trig_router import dtr_pkg::*; #(
  parameter  int NUM_CH   = 4,
  parameter  int NUM_PAIR = 2,
  localparam int CFG_REGS = (NUM_CH * SEL_W + BYTE_W - 1) / BYTE_W,
  localparam int CFG_AW   = (CFG_REGS > 1) ? $clog2(CFG_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic [NUM_CH-1:0]   sw_trig,
  input  logic [NUM_CH-1:0]   dma_en,
  input  logic [NUM_CH-1:0]   edge_pin,
  input  logic [NUM_CH-1:0]   port_grp_a,
  input  logic [NUM_CH-1:0]   port_grp_b,
  input  logic [NUM_CH-1:0]   tmr8_uf,
  input  logic [NUM_CH-1:0]   tmr16_cmpb,
  input  logic [NUM_CH-1:0]   tmr16_cmpa,
  input  logic [NUM_PAIR-1:0] tmr16x_cmpb,
  input  logic [NUM_PAIR-1:0] tmr16x_cmpa,
  input  logic [NUM_PAIR-1:0] sio_rx_full,
  input  logic [NUM_PAIR-1:0] sio_tx_empty,
  input  logic                adc_done,
  input  logic [NUM_CH-1:0]   i2c_rd_req,
  input  logic [NUM_CH-1:0]   i2c_wr_req,
  output logic [NUM_CH-1:0]   dma_req
);

  // named internal events, visible to the bound checker
  logic [NUM_CH*SEL_W-1:0] chan_sel;
  logic [NUM_CH-1:0]       pin_prev;
  logic [NUM_CH-1:0]       pin_rise;
  logic [NUM_CH-1:0]       pin_fall;

  dtr_cfg_regs #(.NUM_CH(NUM_CH), .AW(CFG_AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .sel_flat (chan_sel)
  );

  dtr_edge_det #(.W(NUM_CH)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (edge_pin),
    .pin_q (pin_prev),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int P = pair_of(c, NUM_PAIR);
    logic [SRC_COUNT-1:0] srcs;

    always_comb begin
      srcs               = '0;
      srcs[SRC_SW]       = sw_trig[c];
      srcs[SRC_PIN_FALL] = pin_fall[c];
      srcs[SRC_PIN_RISE] = pin_rise[c];
      srcs[SRC_GRP_A]    = port_grp_a[c];
      srcs[SRC_GRP_B]    = port_grp_b[c];
      srcs[SRC_T8_UF]    = tmr8_uf[c];
      srcs[SRC_T16_CB]   = tmr16_cmpb[c];
      srcs[SRC_T16_CA]   = tmr16_cmpa[c];
      srcs[SRC_T16X_CB]  = tmr16x_cmpb[P];
      srcs[SRC_T16X_CA]  = tmr16x_cmpa[P];
      srcs[SRC_SIO_RX]   = sio_rx_full[P];
      srcs[SRC_SIO_TX]   = sio_tx_empty[P];
      srcs[SRC_ADC]      = adc_done;
      srcs[SRC_I2C_RD]   = i2c_rd_req[c];
      srcs[SRC_I2C_WR]   = i2c_wr_req[c];
      srcs[SRC_RSVD]     = 1'b0;
    end

    dtr_chan_sel u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .srcs  (srcs),
      .code  (chan_sel[c*SEL_W +: SEL_W]),
      .en    (dma_en[c]),
      .req   (dma_req[c])
    );
  end

endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       sw_trig,
  input logic [NUM_CH-1:0]       dma_en,
  input logic [NUM_CH-1:0]       edge_pin,
  input logic [NUM_CH-1:0]       pin_prev,
  input logic [NUM_CH*SEL_W-1:0] chan_sel,
  input logic [NUM_CH-1:0]       dma_req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [SEL_W-1:0] code;
    assign code = chan_sel[c*SEL_W +: SEL_W];

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en[c] |=> !dma_req[c]);

    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (code == {SEL_W{1'b1}}) |=> !dma_req[c]);

    a_r3_sw_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0 && dma_en[c] && sw_trig[c]) |=> dma_req[c]);

    a_r3_sw_only_source: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0 && !sw_trig[c]) |=> !dma_req[c]);

    a_r4_fall_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (code == SEL_W'(1) && dma_en[c] && pin_prev[c] && !edge_pin[c]) |=> dma_req[c]);

    a_r4_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (code == SEL_W'(1) && (pin_prev[c] == edge_pin[c])) |=> !dma_req[c]);

    a_r5_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (code == SEL_W'(2) && dma_en[c] && !pin_prev[c] && edge_pin[c]) |=> dma_req[c]);

    a_r5_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (code == SEL_W'(2) && (pin_prev[c] == edge_pin[c])) |=> !dma_req[c]);
  end

endmodule

bind dma_trig_router dtr_checker #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dtr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_trig  (sw_trig),
  .dma_en   (dma_en),
  .edge_pin (edge_pin),
  .pin_prev (pin_prev),
  .chan_sel (chan_sel),
  .dma_req  (dma_req)
);

// File: tb/test_dma_trig_router.sv
`timescale 1ns/1ps
module test_dma_trig_router;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [0:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] sw_trig = '0, dma_en = '0, edge_pin = '0;
  logic [3:0] port_grp_a = '0, port_grp_b = '0, tmr8_uf = '0;
  logic [3:0] tmr16_cmpb = '0, tmr16_cmpa = '0;
  logic [1:0] tmr16x_cmpb = '0, tmr16x_cmpa = '0, sio_rx_full = '0, sio_tx_empty = '0;
  logic       adc_done = 1'b0;
  logic [3:0] i2c_rd_req = '0, i2c_wr_req = '0;
  logic [3:0] dma_req;

  dma_trig_router i_dma_trig_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sw_trig(sw_trig), .dma_en(dma_en),
    .edge_pin(edge_pin), .port_grp_a(port_grp_a), .port_grp_b(port_grp_b),
    .tmr8_uf(tmr8_uf), .tmr16_cmpb(tmr16_cmpb), .tmr16_cmpa(tmr16_cmpa),
    .tmr16x_cmpb(tmr16x_cmpb), .tmr16x_cmpa(tmr16x_cmpa),
    .sio_rx_full(sio_rx_full), .sio_tx_empty(sio_tx_empty),
    .adc_done(adc_done), .i2c_rd_req(i2c_rd_req), .i2c_wr_req(i2c_wr_req),
    .dma_req(dma_req)
  );

  always #4 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  string tag     = "R1";
  bit    finished = 1'b0;

  // behavioural reference: codes held as integers, previous pin levels
  int         m_code [4];
  logic [3:0] m_prev = '0;
  logic [3:0] m_exp  = '0;

  function automatic logic ref_src(int ch, int code);
    int pr = ch % 2;
    case (code)
      0:  return sw_trig[ch];
      1:  return m_prev[ch] && !edge_pin[ch];
      2:  return !m_prev[ch] && edge_pin[ch];
      3:  return port_grp_a[ch];
      4:  return port_grp_b[ch];
      5:  return tmr8_uf[ch];
      6:  return tmr16_cmpb[ch];
      7:  return tmr16_cmpa[ch];
      8:  return tmr16x_cmpb[pr];
      9:  return tmr16x_cmpa[pr];
      10: return sio_rx_full[pr];
      11: return sio_tx_empty[pr];
      12: return adc_done;
      13: return i2c_rd_req[ch];
      14: return i2c_wr_req[ch];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_exp  = '0;
      m_prev = '0;
      for (int c = 0; c < 4; c++) m_code[c] = 0;
    end else begin
      for (int c = 0; c < 4; c++) m_exp[c] = dma_en[c] && ref_src(c, m_code[c]);
      if (cfg_we) begin
        m_code[2*cfg_addr]     = int'(cfg_wdata[3:0]);
        m_code[2*cfg_addr + 1] = int'(cfg_wdata[7:4]);
      end
      m_prev = edge_pin;
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      for (int c = 0; c < 4; c++) begin
        n_tests++;
        if (dma_req[c] !== m_exp[c]) begin
          n_fail++;
          $display("FAIL %s: ch%0d dma_req=%b expected %b at cycle %0d",
                   tag, c, dma_req[c], m_exp[c], cycles);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected under 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_all(int code);
    cfg_write(1'b0, {4'(code), 4'(code)});
    cfg_write(1'b1, {4'(code), 4'(code)});
  endtask

  task automatic clear_pulses();
    sw_trig = '0; port_grp_a = '0; port_grp_b = '0; tmr8_uf = '0;
    tmr16_cmpb = '0; tmr16_cmpa = '0; tmr16x_cmpb = '0; tmr16x_cmpa = '0;
    sio_rx_full = '0; sio_tx_empty = '0; adc_done = 1'b0;
    i2c_rd_req = '0; i2c_wr_req = '0;
  endtask

  // one event on a source family, then two quiet cycles
  task automatic pulse(int fam, logic [3:0] p);
    @(negedge clk);
    case (fam)
      0:  sw_trig = p;
      1:  edge_pin = edge_pin ^ p;
      2:  port_grp_a = p;
      3:  port_grp_b = p;
      4:  tmr8_uf = p;
      5:  tmr16_cmpb = p;
      6:  tmr16_cmpa = p;
      7:  tmr16x_cmpb = p[1:0];
      8:  tmr16x_cmpa = p[1:0];
      9:  sio_rx_full = p[1:0];
      10: sio_tx_empty = p[1:0];
      11: adc_done = p[0];
      12: i2c_rd_req = p;
      default: i2c_wr_req = p;
    endcase
    @(negedge clk);
    clear_pulses();
    idle(1);
  endtask

  task automatic sweep_families(logic [3:0] p);
    for (int f = 0; f < 14; f++) pulse(f, p);
  endtask

  initial begin
    // R1: reset holds requests low even with a strike pending
    tag = "R1";
    dma_en = 4'hF;
    sw_trig = 4'hF;
    idle(3);
    sw_trig = '0;
    rst_n = 1'b1;
    idle(3);
    // R1/R3: default code is the software strike
    tag = "R3";
    pulse(0, 4'b0101);
    pulse(0, 4'b1010);
    pulse(0, 4'hF);
    // R8: disabled channels stay quiet
    tag = "R8";
    dma_en = 4'b0011;
    pulse(0, 4'hF);
    pulse(2, 4'hF);
    dma_en = 4'hF;
    // R2: nibble packing; channels 1 and 2 on group A, 0 and 3 on software
    tag = "R2";
    cfg_write(1'b0, 8'h30);
    cfg_write(1'b1, 8'h03);
    pulse(2, 4'hF);
    pulse(0, 4'hF);
    // R3: a strike is ignored on a channel whose code is not 0000
    tag = "R3";
    pulse(0, 4'b0110);
    // R4: falling edges only, levels do not retrigger
    tag = "R4";
    set_all(1);
    @(negedge clk) edge_pin = 4'hF;
    idle(3);
    @(negedge clk) edge_pin = 4'h0;
    idle(3);
    @(negedge clk) edge_pin = 4'b0101;
    idle(2);
    @(negedge clk) edge_pin = 4'b1010;
    idle(2);
    // R5: rising edges only
    tag = "R5";
    set_all(2);
    @(negedge clk) edge_pin = 4'hF;
    idle(3);
    @(negedge clk) edge_pin = 4'h0;
    idle(3);
    @(negedge clk) edge_pin = 4'b0110;
    idle(2);
    // R6/R7: every code against every family, one bit at a time
    for (int code = 3; code <= 14; code++) begin
      tag = (code >= 8 && code <= 12) ? "R7" : "R6";
      set_all(code);
      sweep_families(4'b0001);
      sweep_families(4'b0010);
      sweep_families(4'b0100);
      sweep_families(4'b1000);
    end
    // R9: reserved code never requests
    tag = "R9";
    set_all(15);
    sweep_families(4'hF);
    // R10: back-to-back events give back-to-back requests
    tag = "R10";
    set_all(5);
    @(negedge clk) tmr8_uf = 4'b1001;
    @(negedge clk) tmr8_uf = 4'b1111;
    @(negedge clk) tmr8_uf = 4'b0000;
    idle(3);
    @(negedge clk) tmr8_uf = 4'b0100;
    @(negedge clk) tmr8_uf = 4'b0000;
    idle(3);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule